// File: doc/BRIEF.md
# Pre/Post Trigger Cell Capture

This block records ATM cells taken from a received byte-wide stream into a ring memory that holds a fixed number of whole cells (1500 by default, 53 bytes each). A cell begins on a byte that carries the cell-start marker. The following bytes fill the rest of that cell. The cell is committed to memory only when its last byte has arrived.

Software arms the block in one of two modes. In manual mode the block waits for a capture request and then stores the next full memory's worth of cells. In event mode it writes cells into the ring without stopping. After the first qualifying trigger it takes a fixed number of further cells (750 by default) and then freezes. The memory then holds the cells from before the event and the cells from after it. Triggers are the selected bits of a small vector of upstream status flags (cell loss, header error, PRBS error, sequence-number byte error).

When a capture completes, the block raises a done flag and reports the memory index of the oldest stored cell. Any stored byte can then be read through an address/data port.

Top module: `cell_capture`

## Requirements
- R1: After reset, `done` is 0 and `start_idx` is 0. Nothing is stored until the block is armed.
- R2: A cell starts on a byte with `in_valid` and `in_sop` both high. Later bytes with `in_valid` high and `in_sop` low fill byte positions 1 to CELL_BYTES-1, and idle cycles may fall between them. Bytes that arrive outside a cell are ignored. A start marker in the middle of a cell drops the partial cell and starts a new one.
- R3: In manual mode (`mode_event`=0 when `arm` pulses), the first DEPTH_CELLS cells that complete after the cycle of a `manual_req` pulse are stored at indices 0 upward, in order of arrival. `done` rises in the cycle after the last byte of the final cell, and `start_idx` is then 0.
- R4: In event mode (`mode_event`=1 when `arm` pulses), each completed cell is written at the next ring index, which wraps after DEPTH_CELLS-1. The trigger is the OR of `evt_flags & evt_sel`. After an accepted trigger, the block stores DEPTH_CELLS-PRE_CELLS more cells and then sets `done`. `start_idx` becomes the index that follows the last write, which is the index of the oldest stored cell.
- R5: In event mode, a trigger is ignored while fewer than PRE_CELLS cells have been stored since arming. A trigger arriving when exactly PRE_CELLS cells are stored is accepted.
- R6: Only the first accepted trigger counts. Triggers during the post-trigger phase do not change how many cells are captured.
- R7: Flag bits whose `evt_sel` bit is 0 never trigger. The bit order is: bit 0 cell loss, bit 1 header error, bit 2 PRBS error, bit 3 sequence-number byte error.
- R8: `done` stays high until the next `arm` pulse. An `arm` pulse clears `done` in the next cycle and restarts the selected mode at index 0.
- R9: `rd_data` gives byte `rd_byte` (byte 0 is the first byte received) of the cell stored at index `rd_cell`, one clock after the address is applied.
- R10: While `done` is high, incoming cells do not change the memory.
- R11: `manual_req` has no effect unless the block is armed in manual mode and still waiting for the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present |
| in_sop | input | 1 | Byte is the first of a cell |
| in_data | input | 8 | Received byte |
| arm | input | 1 | Pulse: start a new capture |
| mode_event | input | 1 | Mode sampled at arm: 0 manual, 1 event |
| manual_req | input | 1 | Pulse: manual capture request |
| evt_flags | input | NUM_EVT | Upstream error status flags |
| evt_sel | input | NUM_EVT | Trigger enable per flag |
| rd_cell | input | clog2(DEPTH_CELLS) | Readback cell index |
| rd_byte | input | clog2(CELL_BYTES) | Readback byte position |
| rd_data | output | 8 | Readback byte, one cycle latency |
| done | output | 1 | Capture complete |
| start_idx | output | clog2(DEPTH_CELLS) | Index of the oldest stored cell |

## Verification
A wrong write pointer or a fill count that is off by one shows up first at `start_idx` when the capture completes. It also shows up as cells rotated by one place when read back, so each cell must be checked by tag and position. A trigger qualifier or post-trigger counter that is wrong moves the rising edge of `done` to a different cell boundary, and a comparison on every clock catches this within one cell time. A bad byte-position counter in the assembler corrupts byte positions in every stored cell. It becomes visible as soon as the first cell is read back.

// File: rtl/cap_pkg.sv
package cap_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_MAN,
      ST_RING,
      ST_POST,
      ST_DONE
   } cap_state_t;
endpackage

// File: rtl/cap_cell_asm.sv
module cap_cell_asm
   import cap_pkg::*;
#(
   parameter int CELL_BYTES = 53
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic                         in_sop,
   input  logic [BYTE_W-1:0]            in_data,
   output logic                         cell_done,
   output logic [CELL_BYTES*BYTE_W-1:0] cell_row
);
   localparam int BW    = $clog2(CELL_BYTES);
   localparam int ROW_W = CELL_BYTES * BYTE_W;

   logic [ROW_W-1:0] row_q, row_nxt;
   logic [BW-1:0]    cnt_q, wr_idx;
   logic             in_cell_q, accept, last;

   always_comb begin
      wr_idx = in_sop ? '0 : cnt_q;
      accept = in_valid && (in_sop || in_cell_q);
      last   = accept && (wr_idx == BW'(CELL_BYTES - 1));
   end

   // one byte lane per cell position
   for (genvar k = 0; k < CELL_BYTES; k++) begin : g_lane
      assign row_nxt[k*BYTE_W +: BYTE_W] = (accept && wr_idx == BW'(k)) ?
                                           in_data : row_q[k*BYTE_W +: BYTE_W];
   end

   assign cell_done = last;
   assign cell_row  = row_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q     <= '0;
         cnt_q     <= '0;
         in_cell_q <= 1'b0;
      end else if (accept) begin
         row_q     <= row_nxt;
         cnt_q     <= last ? '0 : wr_idx + 1'b1;
         in_cell_q <= !last;
      end
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) < CELL_BYTES);
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
   import cap_pkg::*;
#(
   parameter int DEPTH   = 1500,
   parameter int PRE     = 750,
   parameter int NUM_EVT = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm,
   input  logic                     mode_event,
   input  logic                     manual_req,
   input  logic [NUM_EVT-1:0]       evt_flags,
   input  logic [NUM_EVT-1:0]       evt_sel,
   input  logic                     cell_done,
   output logic                     we,
   output logic [$clog2(DEPTH)-1:0] waddr,
   output logic                     done,
   output logic [$clog2(DEPTH)-1:0] oldest
);
   localparam int AW   = $clog2(DEPTH);
   localparam int POST = DEPTH - PRE;
   localparam int FW   = $clog2(PRE + 1);
   localparam int PW   = $clog2(POST + 1);

   cap_state_t    state_q;
   logic [AW-1:0] wptr_q, wptr_inc, oldest_q;
   logic [FW-1:0] fill_q;
   logic [PW-1:0] pcnt_q;
   logic          done_q, hit, wrap, storing;

   always_comb begin
      hit      = |(evt_flags & evt_sel);
      wrap     = (wptr_q == AW'(DEPTH - 1));
      wptr_inc = wrap ? '0 : wptr_q + 1'b1;
      storing  = (state_q == ST_MAN) || (state_q == ST_RING) || (state_q == ST_POST);
      we       = cell_done && !arm && storing;
   end

   assign waddr  = wptr_q;
   assign done   = done_q;
   assign oldest = oldest_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         wptr_q   <= '0;
         fill_q   <= '0;
         pcnt_q   <= '0;
         done_q   <= 1'b0;
         oldest_q <= '0;
      end else if (arm) begin
         state_q <= mode_event ? ST_RING : ST_WAIT;
         wptr_q  <= '0;
         fill_q  <= '0;
         pcnt_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         if (we) wptr_q <= wptr_inc;
         case (state_q)
            ST_WAIT: if (manual_req) state_q <= ST_MAN;
            ST_MAN: begin
               if (cell_done && wrap) begin
                  state_q  <= ST_DONE;
                  done_q   <= 1'b1;
                  oldest_q <= wptr_inc;
               end
            end
            ST_RING: begin
               if (cell_done && fill_q != FW'(PRE)) fill_q <= fill_q + 1'b1;
               if (hit && fill_q == FW'(PRE)) begin
                  state_q <= ST_POST;
                  pcnt_q  <= '0;
               end
            end
            ST_POST: begin
               if (cell_done) begin
                  pcnt_q <= pcnt_q + 1'b1;
                  if (pcnt_q == PW'(POST - 1)) begin
                     state_q  <= ST_DONE;
                     done_q   <= 1'b1;
                     oldest_q <= wptr_inc;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R8
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !arm) |=> done_q);
   // R8
   rearm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> !done_q);
   // R10
   no_wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !we);
   // R5
   early_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RING && fill_q != FW'(PRE) && !arm) |=> state_q != ST_POST);
   // R6
   post_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_POST) |-> int'(pcnt_q) < POST);
endmodule

// File: rtl/cap_store.sv
module cap_store
   import cap_pkg::*;
#(
   parameter int DEPTH      = 1500,
   parameter int CELL_BYTES = 53
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [$clog2(DEPTH)-1:0]     waddr,
   input  logic [CELL_BYTES*BYTE_W-1:0] wdata,
   input  logic [$clog2(DEPTH)-1:0]     rd_cell,
   input  logic [$clog2(CELL_BYTES)-1:0] rd_byte,
   output logic [BYTE_W-1:0]            rd_data
);
   localparam int ROW_W = CELL_BYTES * BYTE_W;
   localparam int BW    = $clog2(CELL_BYTES);

   logic [ROW_W-1:0] mem [DEPTH];
   logic [ROW_W-1:0] rd_row_q;
   logic [BW-1:0]    rd_sel_q;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rd_row_q <= (int'(rd_cell) < DEPTH) ? mem[rd_cell] : '0;
      rd_sel_q <= rd_byte;
   end

   assign rd_data = (int'(rd_sel_q) < CELL_BYTES) ?
                    rd_row_q[rd_sel_q*BYTE_W +: BYTE_W] : '0;

   // R9
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> int'(waddr) < DEPTH);
endmodule

// File: rtl/cell_capture.sv
module cell_capture
   import cap_pkg::*;
#(
   parameter int CELL_BYTES  = 53,
   parameter int DEPTH_CELLS = 1500,
   parameter int PRE_CELLS   = 750,
   parameter int NUM_EVT     = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic                            in_sop,
   input  logic [7:0]                      in_data,
   input  logic                            arm,
   input  logic                            mode_event,
   input  logic                            manual_req,
   input  logic [NUM_EVT-1:0]              evt_flags,
   input  logic [NUM_EVT-1:0]              evt_sel,
   input  logic [$clog2(DEPTH_CELLS)-1:0]  rd_cell,
   input  logic [$clog2(CELL_BYTES)-1:0]   rd_byte,
   output logic [7:0]                      rd_data,
   output logic                            done,
   output logic [$clog2(DEPTH_CELLS)-1:0]  start_idx
);
   localparam int AW    = $clog2(DEPTH_CELLS);
   localparam int ROW_W = CELL_BYTES * BYTE_W;

   if (CELL_BYTES < 2) begin : g_bad_cell
      $error("cell_capture: CELL_BYTES must be at least 2");
   end
   if (PRE_CELLS < 1 || PRE_CELLS >= DEPTH_CELLS) begin : g_bad_split
      $error("cell_capture: PRE_CELLS must lie in 1..DEPTH_CELLS-1");
   end
   if (NUM_EVT < 1) begin : g_bad_evt
      $error("cell_capture: NUM_EVT must be at least 1");
   end

   logic             cell_done, we;
   logic [ROW_W-1:0] cell_row;
   logic [AW-1:0]    waddr;

   cap_cell_asm #(.CELL_BYTES(CELL_BYTES)) i_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sop    (in_sop),
      .in_data   (in_data),
      .cell_done (cell_done),
      .cell_row  (cell_row)
   );

   cap_ctrl #(.DEPTH(DEPTH_CELLS), .PRE(PRE_CELLS), .NUM_EVT(NUM_EVT)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .mode_event (mode_event),
      .manual_req (manual_req),
      .evt_flags  (evt_flags),
      .evt_sel    (evt_sel),
      .cell_done  (cell_done),
      .we         (we),
      .waddr      (waddr),
      .done       (done),
      .oldest     (start_idx)
   );

   cap_store #(.DEPTH(DEPTH_CELLS), .CELL_BYTES(CELL_BYTES)) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .waddr   (waddr),
      .wdata   (cell_row),
      .rd_cell (rd_cell),
      .rd_byte (rd_byte),
      .rd_data (rd_data)
   );
endmodule

// File: tb/test_cell_capture.sv
module test_cell_capture;
   localparam int CB  = 5;
   localparam int D   = 8;
   localparam int PRE = 4;
   localparam int NE  = 4;
   localparam int AW  = $clog2(D);
   localparam int BW  = $clog2(CB);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid, in_sop, arm, mode_event, manual_req;
   logic [7:0]    in_data;
   logic [NE-1:0] evt_flags, evt_sel;
   logic [AW-1:0] rd_cell;
   logic [BW-1:0] rd_byte;
   logic [7:0]    rd_data;
   logic          done;
   logic [AW-1:0] start_idx;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   cell_capture #(.CELL_BYTES(CB), .DEPTH_CELLS(D), .PRE_CELLS(PRE), .NUM_EVT(NE)) i_cell_capture (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
      .arm(arm), .mode_event(mode_event), .manual_req(manual_req),
      .evt_flags(evt_flags), .evt_sel(evt_sel), .rd_cell(rd_cell), .rd_byte(rd_byte),
      .rd_data(rd_data), .done(done), .start_idx(start_idx)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural reference: cell framing and capture progress
   int m_state = 0, m_wptr = 0, m_fill = 0, m_pcnt = 0;
   int m_done = 0, m_oldest = 0, m_incell = 0, m_cnt = 0;

   always @(posedge clk) begin
      bit cmpl;
      bit hit;
      if (!rst_n) begin
         m_state = 0; m_wptr = 0; m_fill = 0; m_pcnt = 0;
         m_done = 0; m_oldest = 0; m_incell = 0; m_cnt = 0;
      end else begin
         cmpl = 0;
         if (in_valid) begin
            if (in_sop) begin m_cnt = 1; m_incell = 1; end
            else if (m_incell) m_cnt++;
            if (m_incell && m_cnt == CB) begin cmpl = 1; m_incell = 0; end
         end
         hit = (evt_flags & evt_sel) != 0;
         if (arm) begin
            m_done = 0; m_wptr = 0; m_fill = 0; m_pcnt = 0;
            m_state = mode_event ? 3 : 1;
         end else begin
            case (m_state)
               1: if (manual_req) m_state = 2;
               2: if (cmpl) begin
                     m_wptr = m_wptr + 1;
                     if (m_wptr == D) begin m_wptr = 0; m_done = 1; m_oldest = 0; m_state = 5; end
                  end
               3: begin
                     if (hit && m_fill >= PRE) begin m_state = 4; m_pcnt = 0; end
                     if (cmpl) begin
                        m_wptr = (m_wptr + 1) % D;
                        if (m_fill < PRE) m_fill++;
                     end
                  end
               4: if (cmpl) begin
                     m_wptr = (m_wptr + 1) % D;
                     m_pcnt++;
                     if (m_pcnt == D - PRE) begin m_done = 1; m_oldest = m_wptr; m_state = 5; end
                  end
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R8 done flag per clock", int'(done), m_done);
         check("R4 start index per clock", int'(start_idx), m_oldest);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual %0d expected <= 20000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [7:0] pat(int tag, int b);
      return 8'((tag * 16 + b * 3 + 1) & 255);
   endfunction

   task automatic drive(bit v, bit s, bit [7:0] d, bit a, bit mr, bit [NE-1:0] ev);
      @(negedge clk);
      in_valid = v; in_sop = s; in_data = d; arm = a; manual_req = mr; evt_flags = ev;
   endtask

   task automatic idle(int n);
      repeat (n) drive(0, 0, 8'h00, 0, 0, '0);
   endtask

   task automatic send_cell(int tag, bit [NE-1:0] ev);
      for (int b = 0; b < CB; b++) begin
         drive(1, b == 0, pat(tag, b), 0, 0, (b == 0) ? ev : '0);
         if (b == 2 && tag % 2 == 1) idle(1);
      end
      idle(1);
   endtask

   task automatic arm_cap(bit m, bit [NE-1:0] sel);
      mode_event = m;
      evt_sel    = sel;
      drive(0, 0, 8'h00, 1, 0, '0);
      idle(1);
      check("R8 arm clears done", int'(done), 0);
   endtask

   task automatic expect_cell(int c, int tag, string req);
      for (int b = 0; b < CB; b++) begin
         @(negedge clk);
         rd_cell = AW'(c);
         rd_byte = BW'(b);
         @(negedge clk);
         check(req, int'(rd_data), int'(pat(tag, b)));
      end
   endtask

   initial begin
      rst_n = 0; in_valid = 0; in_sop = 0; in_data = 0; arm = 0; mode_event = 0;
      manual_req = 0; evt_flags = '0; evt_sel = '0; rd_cell = '0; rd_byte = '0;
      idle(3);
      rst_n = 1;
      idle(1);
      check("R1 reset done", int'(done), 0);
      check("R1 reset start index", int'(start_idx), 0);

      // R11: request while not armed, cell before arming
      drive(0, 0, 8'h00, 0, 1, '0);
      send_cell(0, '0);
      check("R11 unarmed request ignored", int'(done), 0);

      // manual capture
      arm_cap(0, 4'b1111);
      send_cell(1, '0);
      send_cell(2, '0);
      check("R3 no capture before request", int'(done), 0);
      drive(0, 0, 8'h00, 0, 1, '0);
      drive(1, 0, 8'hEE, 0, 0, '0);   // R2 stray bytes outside a cell
      drive(1, 0, 8'hEF, 0, 0, '0);
      send_cell(3, '0);
      send_cell(4, '0);
      drive(1, 1, pat(99, 0), 0, 0, '0); // R2 partial cell, restarted below
      drive(1, 0, pat(99, 1), 0, 0, '0);
      for (int t = 5; t <= 9; t++) send_cell(t, '0);
      check("R3 done before last cell", int'(done), 0);
      send_cell(10, '0);
      check("R3 manual done", int'(done), 1);
      check("R3 manual start index", int'(start_idx), 0);
      send_cell(11, '0);
      send_cell(12, '0);
      check("R8 done held", int'(done), 1);
      for (int k = 0; k < D; k++) expect_cell(k, 3 + k, "R2 R3 R9 R10 manual contents");

      // event capture, trigger after wrap-free fill of six cells
      arm_cap(1, 4'b0010);
      drive(0, 0, 8'h00, 0, 1, '0);   // R11 request in event mode
      send_cell(20, '0);
      send_cell(21, '0);
      send_cell(22, 4'b0010);          // R5 too early
      send_cell(23, 4'b0001);          // R7 unselected
      send_cell(24, 4'b0100);          // R7 unselected
      send_cell(25, '0);
      send_cell(26, 4'b0010);          // accepted trigger
      send_cell(27, '0);
      send_cell(28, 4'b0010);          // R6 second trigger
      check("R6 not done before fourth post cell", int'(done), 0);
      send_cell(29, '0);
      check("R4 event done", int'(done), 1);
      check("R4 event start index", int'(start_idx), 2);
      send_cell(30, '0);
      for (int k = 0; k < D; k++) expect_cell((2 + k) % D, 22 + k, "R4 R5 R6 R7 R11 event window");

      // event capture, trigger exactly at the pre-fill boundary
      arm_cap(1, 4'b1000);
      send_cell(40, '0);
      send_cell(41, '0);
      send_cell(42, '0);
      send_cell(43, 4'b1000);          // R5 three stored: ignored
      send_cell(44, 4'b1000);          // R5 four stored: accepted
      send_cell(45, '0);
      send_cell(46, '0);
      check("R5 boundary not yet done", int'(done), 0);
      send_cell(47, '0);
      check("R5 boundary done", int'(done), 1);
      check("R4 boundary start index", int'(start_idx), 0);
      for (int k = 0; k < D; k++) expect_cell(k, 40 + k, "R5 R9 boundary window");

      idle(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule